// File: doc/BRIEF.md
# Echo Delay Line Address Generator

This block produces the byte addresses that a stereo echo unit uses to reach its delay line in a 64 KiB byte-addressed audio RAM. On every sample tick it emits one stereo frame of four bytes. The frame holds a left 16-bit word at the frame address and a right 16-bit word two bytes above it. The block also emits a one-cycle read strobe and a write strobe that a global write-disable input can block. The frame address is a page-aligned base plus a running offset. The base comes from an 8-bit page register. The offset steps through a circular buffer whose length is set by a 4-bit delay value.

The delay value is taken up only when the offset wraps back to zero, so a new length never cuts a pass through the buffer short. A delay of zero does not stop memory traffic. Every tick then touches the single frame at the base. Address arithmetic is modulo 65536, so a buffer placed near the top of memory continues from address zero.

Top module: `echo_addr_gen`

## Requirements
- R1: The frame base is baseReg × 256. baseReg is sampled on the clock edge where sampleTick is high, so a change made between ticks shows in the first tick after it.
- R2: Each tick moves the offset 4 bytes forward, and frameAddrL is always a multiple of 4.
- R3: While the latched delay is 0, every tick addresses the base frame (offset 0).
- R4: With a latched delay D greater than 0, the buffer spans D × 2048 bytes. The offset runs 0, 4, …, D×2048−4 and then returns to 0, which is D × 512 ticks per pass.
- R5: delayReg is latched only on a tick where the offset returns to 0, or where the latched delay is 0. After reset the latched delay is 0, so the first tick latches it. A change made in the middle of a pass takes effect only after that pass completes.
- R6: Frame addresses are computed modulo 65536. An offset that carries past 0xFFFF continues at 0x0000.
- R7: rdEn pulses on every tick. wrEn pulses on a tick only if writeDisable is 0 at that tick.
- R8: frameAddrR always equals frameAddrL + 2 (modulo 65536).
- R9: rdEn and wrEn are high only in the cycle after a clock edge with sampleTick high, including on back-to-back ticks. Between ticks both strobes are low and the addresses hold.
- R10: While rstN is low, both addresses and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle request for the next sample frame |
| baseReg | input | 8 | Buffer start page |
| delayReg | input | 4 | Requested delay, in units of 2048 bytes |
| writeDisable | input | 1 | Blocks write strobes when high |
| frameAddrL | output | 16 | Byte address of the left word |
| frameAddrR | output | 16 | Byte address of the right word |
| rdEn | output | 1 | Read strobe, one cycle per tick |
| wrEn | output | 1 | Write strobe, one cycle per permitted tick |

## Verification
A zero delay is run first. It separates a generator that parks on the base frame from one that walks off it. A delay of 1 is then run through a full pass. Partway through that pass the delay register is changed to 2. This shows whether the wrap point is exactly 512 ticks and whether the new length waits for the pass to end. The 2-delay pass runs with the base at the top page, so it exercises the carry out of 16 bits. Next come a base change between ticks, ticks under write-disable and back-to-back ticks. These tell apart base sampling, write gating and strobe timing, while reads carry on throughout.

// File: rtl/echo_addr_pkg.sv
package echo_addr_pkg;
  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic capture;     // register a frame address this cycle
    logic advance;     // step the offset by one frame
    logic clear;       // return the offset to zero
    logic allowWrite;  // the write strobe may fire
  } echoStrobe_t;
endpackage

// File: rtl/echo_addr_ctrl.sv
module echo_addr_ctrl
  import echo_addr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 4,
  parameter int LEN_SHIFT   = 11,
  parameter int FRAME_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic [LEN_W-1:0]  delayReg,
  input  logic              writeDisable,
  input  logic [ADDR_W-1:0] offset,
  output echoStrobe_t       strobe
);
  localparam int LB_W = ADDR_W + 1;

  logic [LEN_W-1:0] lenHold;
  logic [LB_W-1:0]  lenBytes;
  logic [LB_W-1:0]  nextOffset;
  logic             atEnd;

  always_comb begin
    lenBytes   = LB_W'(lenHold) << LEN_SHIFT;
    nextOffset = LB_W'(offset) + LB_W'(FRAME_BYTES);
    atEnd      = (lenHold == '0) || (nextOffset >= lenBytes);
  end

  always_comb begin
    strobe.capture    = sampleTick;
    strobe.advance    = sampleTick && !atEnd;
    strobe.clear      = sampleTick && atEnd;
    strobe.allowWrite = !writeDisable;
  end

  // The length is taken up only at the wrap point
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenHold <= '0;
    end else if (strobe.clear) begin
      lenHold <= delayReg;
    end
  end
endmodule

// File: rtl/echo_addr_dpath.sv
module echo_addr_dpath
  import echo_addr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BASE_W      = 8,
  parameter int FRAME_BYTES = 4,
  parameter int WORD_BYTES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  echoStrobe_t       strobe,
  input  logic [BASE_W-1:0] baseReg,
  output logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] wordAddr [FRAME_BYTES/WORD_BYTES],
  output logic              rdEn,
  output logic              wrEn
);
  localparam int PAGE_SHIFT = ADDR_W - BASE_W;
  localparam int NUM_WORDS  = FRAME_BYTES / WORD_BYTES;

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] frameAddr;

  always_comb begin
    baseAddr  = ADDR_W'(baseReg) << PAGE_SHIFT;
    frameAddr = baseAddr + offset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offset <= '0;
    end else if (strobe.clear) begin
      offset <= '0;
    end else if (strobe.advance) begin
      offset <= offset + ADDR_W'(FRAME_BYTES);
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wordAddr[w] <= '0;
      end else if (strobe.capture) begin
        wordAddr[w] <= frameAddr + ADDR_W'(w * WORD_BYTES);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdEn <= 1'b0;
      wrEn <= 1'b0;
    end else begin
      rdEn <= strobe.capture;
      wrEn <= strobe.capture && strobe.allowWrite;
    end
  end
endmodule

// File: rtl/echo_addr_gen.sv
module echo_addr_gen
  import echo_addr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BASE_W      = 8,
  parameter int LEN_W       = 4,
  parameter int LEN_SHIFT   = 11,
  parameter int FRAME_BYTES = 4,
  parameter int WORD_BYTES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic [BASE_W-1:0] baseReg,
  input  logic [LEN_W-1:0]  delayReg,
  input  logic              writeDisable,
  output logic [ADDR_W-1:0] frameAddrL,
  output logic [ADDR_W-1:0] frameAddrR,
  output logic              rdEn,
  output logic              wrEn
);
  localparam int NUM_WORDS = FRAME_BYTES / WORD_BYTES;

  echoStrobe_t       strobe;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] wordAddr [NUM_WORDS];

  echo_addr_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LEN_SHIFT(LEN_SHIFT), .FRAME_BYTES(FRAME_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .delayReg(delayReg),
    .writeDisable(writeDisable), .offset(offset), .strobe(strobe)
  );

  echo_addr_dpath #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .FRAME_BYTES(FRAME_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseReg(baseReg),
    .offset(offset), .wordAddr(wordAddr), .rdEn(rdEn), .wrEn(wrEn)
  );

  assign frameAddrL = wordAddr[0];
  assign frameAddrR = wordAddr[NUM_WORDS-1];
endmodule

// File: rtl/echo_addr_gen_chk.sv
module echo_addr_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleTick,
  input logic              writeDisable,
  input logic [ADDR_W-1:0] frameAddrL,
  input logic [ADDR_W-1:0] frameAddrR,
  input logic              rdEn,
  input logic              wrEn
);
  // R9: a read strobe only follows a tick edge
  p_rd_after_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> $past(sampleTick));

  // R7: a write strobe needs a read strobe and writes permitted at the tick
  p_wr_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (rdEn && !$past(writeDisable)));

  // R2: frames are 4-byte aligned
  p_frame_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (frameAddrL[1:0] == 2'b00));

  // R8: right word sits two bytes above the left word
  p_right_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (frameAddrR == ADDR_W'(frameAddrL + 2)));

  // R9: addresses hold between ticks
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleTick) |-> ($stable(frameAddrL) && $stable(frameAddrR)));
endmodule

bind echo_addr_gen echo_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .writeDisable(writeDisable),
  .frameAddrL(frameAddrL), .frameAddrR(frameAddrR), .rdEn(rdEn), .wrEn(wrEn)
);

// File: tb/sim_echo_addr_gen.sv
module sim_echo_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleTick = 1'b0;
  logic [7:0]  baseReg = 8'h12;
  logic [3:0]  delayReg = 4'd0;
  logic        writeDisable = 1'b0;
  logic [15:0] frameAddrL, frameAddrR;
  logic        rdEn, wrEn;

  always #2.5 clk = ~clk;

  echo_addr_gen u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .baseReg(baseReg),
    .delayReg(delayReg), .writeDisable(writeDisable),
    .frameAddrL(frameAddrL), .frameAddrR(frameAddrR), .rdEn(rdEn), .wrEn(wrEn)
  );

  typedef struct {
    logic [15:0] l;
    logic [15:0] r;
    logic        w;
    string       req;
  } exp_t;

  exp_t        expQ [$];
  int          checks = 0;
  int          fails  = 0;
  string       curReq = "R10";
  logic [15:0] mOff = 16'd0;
  logic [3:0]  mLen = 4'd0;
  logic [15:0] lastL = 16'd0;
  logic [15:0] lastR = 16'd0;
  logic        monOn = 1'b0;
  logic        tickSeen;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model step: called on the cycle the tick is driven
  task automatic pushExpect();
    exp_t e;
    logic [31:0] lenB;
    e.l = 16'({baseReg, 8'h00} + mOff);
    e.r = 16'(e.l + 16'd2);
    e.w = !writeDisable;
    e.req = curReq;
    expQ.push_back(e);
    lenB = 32'(mLen) * 2048;
    if (mLen == 0 || 32'(mOff) + 4 >= lenB) begin
      mOff = 16'd0;
      mLen = delayReg;
    end else begin
      mOff = mOff + 16'd4;
    end
  endtask

  // Driver: one tick followed by one idle cycle
  task automatic doTick();
    @(negedge clk);
    sampleTick = 1'b1;
    pushExpect();
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  // Driver: two ticks on consecutive cycles (R9)
  task automatic doBurst();
    @(negedge clk);
    sampleTick = 1'b1;
    pushExpect();
    @(negedge clk);
    pushExpect();
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  // Monitor: sample one time unit after each rising edge
  always @(posedge clk) begin
    tickSeen = sampleTick;
    #1;
    if (monOn) begin
      if (tickSeen) begin
        if (expQ.size() == 0) begin
          check("R9", 32'(rdEn), 32'd0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(e.req, 32'(frameAddrL), 32'(e.l));
          check("R8", 32'(frameAddrR), 32'(e.r));
          check("R7", 32'(wrEn), 32'(e.w));
          check("R9", 32'(rdEn), 32'd1);
          lastL = e.l;
          lastR = e.r;
        end
      end else begin
        check("R9", 32'({rdEn, wrEn}), 32'd0);
        check("R9", 32'({frameAddrL, frameAddrR}), 32'({lastL, lastR}));
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", 32'({frameAddrL, frameAddrR}), 32'd0);
    check("R10", 32'({rdEn, wrEn}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;

    // R3: zero delay parks on the base frame
    curReq = "R3";
    repeat (4) doTick();

    // R5: new delay waits for the wrap point; R4: length 1 pass of 512 frames; R2 stepping
    curReq = "R4";
    delayReg = 4'd1;
    doTick();
    for (int i = 0; i < 600; i++) begin
      if (i == 100) begin
        curReq = "R5";
        delayReg = 4'd2;
      end
      if (i == 300) baseReg = 8'hFF;  // R6: top page, carry out of 16 bits
      if (i == 520) curReq = "R6";
      doTick();
    end
    // R6: mid pass offset of 0x100 onward wraps to page zero
    for (int i = 0; i < 1024; i++) begin
      if (i == 200) curReq = "R2";
      doTick();
    end
    check("R6", 32'(lastL[15:8] < 8'hFF), 32'd1);

    // R1: base change between ticks is seen on the next tick
    curReq = "R1";
    baseReg = 8'h40;
    repeat (3) doTick();
    baseReg = 8'h80;
    doTick();

    // R7: writes blocked while reads continue
    curReq = "R7";
    writeDisable = 1'b1;
    repeat (3) doTick();
    writeDisable = 1'b0;
    doTick();

    // R9: back-to-back ticks
    curReq = "R9";
    doBurst();
    writeDisable = 1'b1;
    doBurst();
    repeat (3) @(negedge clk);
    check("R9", 32'(expQ.size()), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule